// File: doc/BRIEF.md
# Mode-Dependent Port Pin Function Multiplexer

This block controls one 8-bit general-purpose port of a microcontroller-style chip. For every pin it decides, each cycle, whether the pin carries a bit of the external address bus, carries an active-low chip-select strobe, behaves as a pure input, or behaves as an ordinary I/O line whose direction and level come from software-written registers. The choice depends on a 3-bit operating mode, an external-expansion flag, one address-enable bit per pin and one chip-select enable for the top pin. The per-pin direction bit changes meaning with that context: it picks address output against input, chip-select output against input, or plain output against input.

Software reaches three registers over a simple synchronous bus: a direction register that can be written but not read back, an output-level register that can be written and read, and a pin-level register that returns the pad inputs after a two-flop synchronizer. The outputs are an output value and an output-enable per pin, which the pad ring combines into the physical drivers. Address and chip-select values come from the bus controller, which sits outside this block, and pass straight through to the pins they own. The reset input is expected to arrive already released in step with the clock.

Top module: `port_pin_mux`

## Requirements
- R1: While reset is held and after its release, the direction and output-level registers hold 0, so in a mode with all pins as plain I/O every pad_oe bit is 0, and a read at bus address 1 returns 0.
- R2: Bus address 0 is the direction register, 1 the output-level register, 2 the pin-level register; a write (bus_we high at a clock edge) to 0 or 1 loads bus_wdata, a new direction shows on pad_oe from the cycle after the write edge, and writes to addresses 2 and 3 change no register.
- R3: With op_mode 3'd1 or 3'd2, pins 0 to 4 always have pad_oe 1 and pad_out equal to the matching addr_hi bit, whatever their direction bits hold.
- R4: Pins 5 and 6 with op_mode 3'd1 or 3'd2, and pins 0 to 6 with op_mode 3'd4 or with op_mode 3'd7 and expand_en 1, obey addr_en bit i: when set, direction 1 drives addr_hi bit i with pad_oe 1 and direction 0 gives pad_oe 0; when clear, the pin is plain I/O.
- R5: In those expanded contexts pin 7 gives priority to addr_en bit 7 (direction picks address output or input), then to cs_top_en (direction picks driving cs_top_n or input), and otherwise is plain I/O.
- R6: A plain I/O pin has pad_oe equal to its direction bit and, when enabled, pad_out equal to its output-level bit; a pin with pad_oe 0 always shows pad_out 0.
- R7: With op_mode 3'd7 and expand_en 0, and with any op_mode other than 1, 2, 4 and 7, all pins are plain I/O and addr_en and cs_top_en have no effect; op_mode 3'd4 ignores expand_en.
- R8: A read at bus address 2 returns pad_in as it was two clock edges earlier, whatever function each pin has.
- R9: A read at bus address 1 returns the last value written to the output-level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| op_mode | input | 3 | Operating mode code |
| expand_en | input | 1 | External expansion flag, used by mode 7 |
| addr_en | input | 8 | Per-pin address enable; bit i owns address line 16+i |
| cs_top_en | input | 1 | Chip-select enable for pin 7 |
| addr_hi | input | 8 | Upper address bits 23:16 from the bus controller |
| cs_top_n | input | 1 | Active-low chip-select strobe from the bus controller |
| bus_addr | input | 2 | Register select for reads and writes |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (direction returns a fixed filler) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Per-pin output value |
| pad_oe | output | 8 | Per-pin output enable |

## Verification
The assertions assume that op_mode, expand_en, addr_en and cs_top_en settle before the clock edge that follows their change and that the context is held across a direction write when the write check applies; the bench changes all of them only at falling edges and holds them for at least one full cycle around each write. The pin-level check assumes pad_in is sampled only at rising edges, which the bench honours by moving pad_in at falling edges. The sweep walks every mode code with both expansion settings, both chip-select enables and a set of enable and direction patterns, so every pin function is entered under every context that can select it.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  typedef enum logic [1:0] {
    PF_GPIO  = 2'd0,
    PF_INPUT = 2'd1,
    PF_ADDR  = 2'd2,
    PF_CS    = 2'd3
  } pin_fn_e;

  localparam int          REG_AW    = 2;
  localparam logic [1:0]  REG_DIR   = 2'd0;
  localparam logic [1:0]  REG_OUT   = 2'd1;
  localparam logic [1:0]  REG_PIN   = 2'd2;

  localparam logic [2:0]  MODE_EXT_A  = 3'd1;
  localparam logic [2:0]  MODE_EXT_B  = 3'd2;
  localparam logic [2:0]  MODE_EXT_C  = 3'd4;
  localparam logic [2:0]  MODE_SINGLE = 3'd7;

  typedef struct packed {
    logic expanded;   // bus pins may take address / strobe roles
    logic wide_addr;  // every pin below the top one is enable-controlled
  } mode_ctx_t;

  function automatic mode_ctx_t decode_mode(input logic [2:0] mode, input logic ext);
    mode_ctx_t c;
    c.expanded  = 1'b0;
    c.wide_addr = 1'b0;
    case (mode)
      MODE_EXT_A, MODE_EXT_B: c.expanded = 1'b1;
      MODE_EXT_C: begin
        c.expanded  = 1'b1;
        c.wide_addr = 1'b1;
      end
      MODE_SINGLE: begin
        c.expanded  = ext;
        c.wide_addr = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs #(
  parameter int PINS = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [pinmux_pkg::REG_AW-1:0]   bus_addr,
  input  logic                            bus_we,
  input  logic [PINS-1:0]                 bus_wdata,
  input  logic [PINS-1:0]                 pin_state,
  output logic [PINS-1:0]                 dir_q,
  output logic [PINS-1:0]                 odr_q,
  output logic [PINS-1:0]                 bus_rdata
);
  import pinmux_pkg::*;

  localparam logic [PINS-1:0] DIR_READ_FILL = {PINS{1'b1}};

  logic            dir_en, odr_en;
  logic [PINS-1:0] dir_d, odr_d;

  // next-state
  always_comb begin
    dir_en = bus_we && (bus_addr == REG_DIR);
    odr_en = bus_we && (bus_addr == REG_OUT);
    dir_d  = bus_wdata;
    odr_d  = bus_wdata;
  end

  // registers with explicit load enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr_q <= '0;
    end else if (odr_en) begin
      odr_q <= odr_d;
    end
  end

  // read path: direction is write-only and returns a filler pattern
  always_comb begin
    case (bus_addr)
      REG_DIR: bus_rdata = DIR_READ_FILL;
      REG_OUT: bus_rdata = odr_q;
      REG_PIN: bus_rdata = pin_state;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pin_state
);

  logic [PINS-1:0] stage_q [STAGES];
  logic [PINS-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = pad_in;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign pin_state = stage_q[STAGES-1];

endmodule

// File: rtl/pinmux_fn_sel.sv
module pinmux_fn_sel #(
  parameter int PINS       = 8,
  parameter int FIXED_PINS = 5
) (
  input  pinmux_pkg::mode_ctx_t            ctx,
  input  logic [PINS-1:0]                  addr_en,
  input  logic                             cs_top_en,
  input  logic [PINS-1:0]                  dir,
  output pinmux_pkg::pin_fn_e [PINS-1:0]   pin_fn
);
  import pinmux_pkg::*;

  localparam int TOP = PINS - 1;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    localparam bit IS_TOP   = (i == TOP);
    localparam bit IS_FIXED = (i < FIXED_PINS) && !IS_TOP;

    pin_fn_e fn;

    if (IS_TOP) begin : g_top
      // address enable beats chip-select enable beats plain I/O
      always_comb begin
        fn = PF_GPIO;
        if (ctx.expanded) begin
          if (addr_en[i]) begin
            fn = dir[i] ? PF_ADDR : PF_INPUT;
          end else if (cs_top_en) begin
            fn = dir[i] ? PF_CS : PF_INPUT;
          end
        end
      end
    end else if (IS_FIXED) begin : g_fixed
      // forced address pin in the narrow expanded modes
      always_comb begin
        fn = PF_GPIO;
        if (ctx.expanded) begin
          if (!ctx.wide_addr) begin
            fn = PF_ADDR;
          end else if (addr_en[i]) begin
            fn = dir[i] ? PF_ADDR : PF_INPUT;
          end
        end
      end
    end else begin : g_mid
      always_comb begin
        fn = PF_GPIO;
        if (ctx.expanded && addr_en[i]) begin
          fn = dir[i] ? PF_ADDR : PF_INPUT;
        end
      end
    end

    assign pin_fn[i] = fn;
  end

endmodule

// File: rtl/pinmux_drive.sv
module pinmux_drive #(
  parameter int PINS = 8
) (
  input  pinmux_pkg::pin_fn_e [PINS-1:0]   pin_fn,
  input  logic [PINS-1:0]                  dir,
  input  logic [PINS-1:0]                  odr,
  input  logic [PINS-1:0]                  addr_hi,
  input  logic                             cs_top_n,
  output logic [PINS-1:0]                  pad_out,
  output logic [PINS-1:0]                  pad_oe
);
  import pinmux_pkg::*;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic strobe;
    if (i == PINS - 1) begin : g_top
      assign strobe = cs_top_n;
    end else begin : g_low
      assign strobe = 1'b0;
    end

    always_comb begin
      case (pin_fn[i])
        PF_ADDR: begin
          pad_oe[i]  = 1'b1;
          pad_out[i] = addr_hi[i];
        end
        PF_CS: begin
          pad_oe[i]  = 1'b1;
          pad_out[i] = strobe;
        end
        PF_GPIO: begin
          pad_oe[i]  = dir[i];
          pad_out[i] = dir[i] & odr[i];
        end
        default: begin
          pad_oe[i]  = 1'b0;
          pad_out[i] = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/port_pin_mux.sv
module port_pin_mux #(
  parameter int PINS        = 8,
  parameter int FIXED_PINS  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_mode,
  input  logic            expand_en,
  input  logic [PINS-1:0] addr_en,
  input  logic            cs_top_en,
  input  logic [PINS-1:0] addr_hi,
  input  logic            cs_top_n,
  input  logic [1:0]      bus_addr,
  input  logic            bus_we,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  import pinmux_pkg::*;

  mode_ctx_t           ctx;
  logic [PINS-1:0]     dir_q;
  logic [PINS-1:0]     odr_q;
  logic [PINS-1:0]     pin_state;
  pin_fn_e [PINS-1:0]  pin_fn;

  assign ctx = decode_mode(op_mode, expand_en);

  pinmux_regs #(.PINS(PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_state (pin_state),
    .dir_q     (dir_q),
    .odr_q     (odr_q),
    .bus_rdata (bus_rdata)
  );

  pinmux_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_in    (pad_in),
    .pin_state (pin_state)
  );

  pinmux_fn_sel #(.PINS(PINS), .FIXED_PINS(FIXED_PINS)) u_fn_sel (
    .ctx       (ctx),
    .addr_en   (addr_en),
    .cs_top_en (cs_top_en),
    .dir       (dir_q),
    .pin_fn    (pin_fn)
  );

  pinmux_drive #(.PINS(PINS)) u_drive (
    .pin_fn    (pin_fn),
    .dir       (dir_q),
    .odr       (odr_q),
    .addr_hi   (addr_hi),
    .cs_top_n  (cs_top_n),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

endmodule

// File: rtl/pinmux_checker.sv
module pinmux_checker #(
  parameter int PINS       = 8,
  parameter int FIXED_PINS = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      op_mode,
  input logic            expand_en,
  input logic [PINS-1:0] addr_en,
  input logic            cs_top_en,
  input logic [PINS-1:0] addr_hi,
  input logic            cs_top_n,
  input logic [1:0]      bus_addr,
  input logic            bus_we,
  input logic [PINS-1:0] bus_wdata,
  input logic [PINS-1:0] bus_rdata,
  input logic [PINS-1:0] pad_in,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] odr_q
);
  localparam int              TOP      = PINS - 1;
  localparam logic [PINS-1:0] LOW_MASK = {1'b0, {(PINS-1){1'b1}}};

  logic narrow_exp, wide_exp, any_exp, plain_io;
  assign narrow_exp = (op_mode == 3'd1) || (op_mode == 3'd2);
  assign wide_exp   = (op_mode == 3'd4) || ((op_mode == 3'd7) && expand_en);
  assign any_exp    = narrow_exp || wide_exp;
  assign plain_io   = !any_exp;

  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cnt <= '0;
    end else if (live_cnt != 2'd3) begin
      live_cnt <= live_cnt + 2'd1;
    end
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0 && plain_io) |=> (!plain_io || pad_oe == $past(bus_wdata)));

  assert_fixed_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_exp |-> (&pad_oe[FIXED_PINS-1:0]) && (pad_out[FIXED_PINS-1:0] == addr_hi[FIXED_PINS-1:0]));

  assert_wide_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wide_exp |-> (((pad_out ^ addr_hi) & pad_oe & addr_en & LOW_MASK) == '0));

  assert_top_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_exp && !addr_en[TOP] && cs_top_en && pad_oe[TOP]) |-> (pad_out[TOP] == cs_top_n));

  assert_quiet_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0));

  assert_plain_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    plain_io |-> (pad_out == (odr_q & pad_oe)));

  assert_pin_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd2 && bus_addr == 2'd2) |-> (bus_rdata == $past(pad_in, 2)));

endmodule

bind port_pin_mux pinmux_checker #(.PINS(PINS), .FIXED_PINS(FIXED_PINS)) u_pinmux_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_mode   (op_mode),
  .expand_en (expand_en),
  .addr_en   (addr_en),
  .cs_top_en (cs_top_en),
  .addr_hi   (addr_hi),
  .cs_top_n  (cs_top_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .odr_q     (odr_q)
);

// File: tb/test_port_pin_mux.sv
`timescale 1ns/1ps
module test_port_pin_mux;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_mode;
  logic       expand_en;
  logic [7:0] addr_en;
  logic       cs_top_en;
  logic [7:0] addr_hi;
  logic       cs_top_n;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  port_pin_mux i_port_pin_mux (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .expand_en(expand_en),
    .addr_en(addr_en), .cs_top_en(cs_top_en), .addr_hi(addr_hi), .cs_top_n(cs_top_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {oe, out} from the requirement text
  function automatic logic [15:0] expect_pins(input logic [2:0] m, input logic ex,
      input logic [7:0] ae, input logic cse, input logic [7:0] dir, input logic [7:0] lvl,
      input logic [7:0] ahi, input logic csn);
    logic [7:0] oe, out;
    bit narrow, expd;
    narrow = (m == 3'd1) || (m == 3'd2);
    expd   = narrow || (m == 3'd4) || (m == 3'd7 && ex);
    for (int p = 0; p < 8; p++) begin
      int f; // 0 plain, 1 input, 2 address, 3 strobe
      f = 0;
      if (expd) begin
        if (p == 7) f = ae[7] ? (dir[7] ? 2 : 1) : (cse ? (dir[7] ? 3 : 1) : 0);
        else if (narrow && p < 5) f = 2;
        else if (ae[p]) f = dir[p] ? 2 : 1;
      end
      case (f)
        0: begin oe[p] = dir[p]; out[p] = dir[p] & lvl[p]; end
        2: begin oe[p] = 1'b1;   out[p] = ahi[p]; end
        3: begin oe[p] = 1'b1;   out[p] = csn; end
        default: begin oe[p] = 1'b0; out[p] = 1'b0; end
      endcase
    end
    return {oe, out};
  endfunction

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] lvl;
    logic [7:0] ae_pat [4];
    logic [7:0] dir_pat [4];
    ae_pat[0] = 8'h00; ae_pat[1] = 8'hFF; ae_pat[2] = 8'h61; ae_pat[3] = 8'h9E;
    dir_pat[0] = 8'h00; dir_pat[1] = 8'hFF; dir_pat[2] = 8'h5A; dir_pat[3] = 8'hC3;

    rst_n = 1'b0; op_mode = 3'd7; expand_en = 1'b0; addr_en = 8'h00; cs_top_en = 1'b0;
    addr_hi = 8'h00; cs_top_n = 1'b1; bus_addr = 2'd0; bus_we = 1'b0; bus_wdata = 8'h00;
    pad_in = 8'h00;

    // R1: reset state while held
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {8'h00, pad_oe}, {8'h00, 8'h00});
    bus_addr = 2'd1; #1;
    check("R1 level reg in reset", {8'h00, bus_rdata}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe after release", {pad_oe, pad_out}, 16'h0000);

    // R9: output-level register read back
    write_reg(2'd1, 8'h3C);
    read_reg(2'd1, rd);
    check("R9 level readback", {8'h00, rd}, 16'h003C);
    write_reg(2'd1, 8'hA5);
    read_reg(2'd1, rd);
    check("R9 level readback 2", {8'h00, rd}, 16'h00A5);
    lvl = 8'hA5;

    // R2: direction timing, one cycle after write edge
    @(negedge clk);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 8'hF0;
    #1 check("R2 oe before edge", {8'h00, pad_oe}, 16'h0000);
    @(negedge clk); bus_we = 1'b0;
    check("R2 oe after edge", {pad_oe, pad_out}, {8'hF0, 8'hF0 & lvl});

    // R2: writes to addresses 2 and 3 change nothing
    write_reg(2'd2, 8'h0F);
    write_reg(2'd3, 8'h0F);
    check("R2 ignored writes oe", {8'h00, pad_oe}, 16'h00F0);
    read_reg(2'd1, rd);
    check("R2 ignored writes level", {8'h00, rd}, {8'h00, lvl});

    // R8: pin-level synchronizer latency, plain and address contexts
    for (int k = 0; k < 2; k++) begin
      logic [7:0] oldv, newv;
      op_mode = (k == 0) ? 3'd7 : 3'd1;
      oldv = pad_in;
      newv = (k == 0) ? 8'h96 : 8'h3B;
      bus_addr = 2'd2;
      repeat (2) @(negedge clk);
      pad_in = newv;
      @(negedge clk); #1;
      check("R8 pin level after one edge", {8'h00, bus_rdata}, {8'h00, oldv});
      @(negedge clk); #1;
      check("R8 pin level after two edges", {8'h00, bus_rdata}, {8'h00, newv});
    end
    op_mode = 3'd7;

    // R3 R4 R5 R6 R7: sweep of contexts
    for (int m = 0; m < 8; m++) begin
      for (int ex = 0; ex < 2; ex++) begin
        for (int cs = 0; cs < 2; cs++) begin
          for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 4; d++) begin
              logic [15:0] e;
              string tag;
              @(negedge clk);
              op_mode   = m[2:0];
              expand_en = ex[0];
              cs_top_en = cs[0];
              addr_en   = ae_pat[a];
              addr_hi   = 8'h5C ^ {m[2:0], a[1:0], d[1:0], ex[0]};
              cs_top_n  = d[0] ^ cs[0];
              write_reg(2'd0, dir_pat[d]);
              e = expect_pins(op_mode, expand_en, addr_en, cs_top_en, dir_pat[d], lvl,
                              addr_hi, cs_top_n);
              if (m == 1 || m == 2) tag = "R3 R4 R5 narrow";
              else if (m == 4 || (m == 7 && ex == 1)) tag = "R4 R5 wide";
              else tag = "R6 R7 plain";
              check({tag, " oe"},  {8'h00, pad_oe},  {8'h00, e[15:8]});
              check({tag, " out"}, {8'h00, pad_out}, {8'h00, e[7:0]});
            end
          end
        end
      end
    end

    // R6: change level register in plain context, pins follow
    op_mode = 3'd0; write_reg(2'd0, 8'hFF);
    write_reg(2'd1, 8'h81);
    check("R6 plain level follows", {pad_oe, pad_out}, 16'hFF81);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule